// File: doc/BRIEF.md
# Byte-Coded Command Program Sequencer

This block runs short programs held in a 256-byte byte-wide SRAM. A host writes a program into the SRAM. It then pulses `start_i` with the program's first address. The sequencer reads one opcode at a time and collects the inline operand bytes that opcode takes. It then acts on the opcode. Some opcodes pulse a statistics collector (clear, run, halt). Others load the collector's channel mask or sample timer. Two opcodes copy a block of bytes back into the same SRAM at an address the program supplies: a dump of the collector's records, or a 10-byte information block. An end opcode finishes the program.

The host mailbox watches three signals. `busy_o` is high while a program runs. `done_o` pulses for one cycle when the program finishes. `err_o` shows whether the program ended on a fault, and it holds that value until the next start. The SRAM is outside the block and has a synchronous read with one cycle of latency. The record bytes come from the collector through a byte-offset lookup port.

States:
- `S_IDLE`: waits for a start.
- `S_FETCH`: drives the program counter to the SRAM.
- `S_LATCH`: takes the returned byte as an opcode or as an operand.
- `S_EXEC`: applies a command that has operands.
- `S_WRITE`: copies a result block into the SRAM.
- `S_FINISH`: finishes cleanly.
- `S_FAULT`: finishes with an error.

Transitions:
- idle→fetch on start.
- fetch→latch normally, or fetch→fault when the program counter is 0xFF.
- latch→fetch after a no-operand opcode or a partial operand.
- latch→exec on the last operand.
- latch→finish on END.
- latch→fault on an unknown opcode.
- exec→fetch or exec→write.
- exec→fault on a bad prescale or a block that would overrun.
- write→fetch after the last byte.
- finish and fault both go back to idle.

Top module: `prog_sequencer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low, the channel mask and the timer are 0, and the stored record address is 0x80. A `start_i` pulse while idle raises `busy_o` on the next cycle and clears `err_o`. A `start_i` pulse while busy is ignored.
- R2: Opcodes 0x10, 0x11 and 0x12 take no operands. Each gives exactly one one-cycle pulse, on `stat_clr_o`, `stat_run_o` or `stat_halt_o` respectively.
- R3: Opcode 0x00 ends the program. `done_o` pulses for one cycle, `busy_o` is low in that cycle, and `err_o` stays 0.
- R4: Opcode 0x14 is followed by a high byte and then a low byte. `chan_mask_o` becomes {high, low}.
- R5: Opcode 0x15 is followed by four bytes: the prescale, the timer value, and two bytes that are ignored. When the prescale is 0, `timer_o` takes the timer value. When the prescale is nonzero, the program ends with an error and `timer_o` keeps its value.
- R6: Opcode 0x13 is followed by one destination byte D. Record bytes 0 to NUM_REC*REC_BYTES-1 are written to SRAM addresses D+k, and D becomes the stored record address.
- R7: Opcode 0x31 is followed by one destination byte D. Ten bytes are written from D onward, in this order: VERSION high, VERSION low, prescale (0), timer, NUM_REC, record address high (0), record address low, then three bytes of zero.
- R8: Any opcode other than 0x00, 0x10 to 0x15 and 0x31 ends the program with `err_o` set.
- R9: If the program counter reaches 0xFF before END, whether at an opcode or at an operand, the program ends with an error. Address 0xFF is never executed.
- R10: A 0x13 or 0x31 block is refused when D plus the block length exceeds 255. The program then ends with an error and nothing is written.
- R11: `mem_we_o` is high only while busy. `err_o` and the channel mask do not change while idle without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| start_addr_i | input | 8 | First program address |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle end-of-program pulse |
| err_o | output | 1 | Last program ended on a fault |
| mem_addr_o | output | 8 | SRAM address |
| mem_we_o | output | 1 | SRAM write enable |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_rdata_i | input | 8 | SRAM read data, one cycle after the address |
| stat_clr_o | output | 1 | Clear pulse to the collector |
| stat_run_o | output | 1 | Run pulse to the collector |
| stat_halt_o | output | 1 | Halt pulse to the collector |
| chan_mask_o | output | 16 | Channel enable mask |
| timer_o | output | 8 | Sample timer value |
| rec_idx_o | output | 8 | Record byte offset being dumped |
| rec_byte_i | input | 8 | Record byte at `rec_idx_o` |

## Verification
The bench builds the block with NUM_REC=2 and REC_BYTES=11, so a record dump is 22 bytes long. That is short enough to sweep every dump destination from 0x20 to 0xFF. The sweep crosses the overrun boundary between 0xE9 and 0xEA. The bench also sweeps every possible first opcode, a walking mask pattern, and the cross of four prescale values with three timer values. Further programs placed at the top of the SRAM reach the 0xFF limit both at an opcode and in the middle of an operand.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
    typedef enum logic [7:0] {
        OP_END  = 8'h00,
        OP_CLR  = 8'h10,
        OP_RUN  = 8'h11,
        OP_HALT = 8'h12,
        OP_DUMP = 8'h13,
        OP_MASK = 8'h14,
        OP_TICK = 8'h15,
        OP_INFO = 8'h31
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_LATCH, S_EXEC, S_WRITE, S_FINISH, S_FAULT
    } state_e;

    localparam int INFO_LEN = 10;
    localparam logic [7:0] LAST_ADDR = 8'hFF;
endpackage

// File: rtl/cseq_decode.sv
module cseq_decode
    import cseq_pkg::*;
(
    input  logic [7:0] op_i,
    output logic       known_o,
    output logic [2:0] n_opnd_o
);
    always_comb begin
        known_o  = 1'b1;
        n_opnd_o = 3'd0;
        case (op_i)
            OP_END, OP_CLR, OP_RUN, OP_HALT: n_opnd_o = 3'd0;
            OP_DUMP, OP_INFO:                n_opnd_o = 3'd1;
            OP_MASK:                         n_opnd_o = 3'd2;
            OP_TICK:                         n_opnd_o = 3'd4;
            default:                         known_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/cseq_info.sv
module cseq_info #(
    parameter logic [15:0] VERSION = 16'h0100,
    parameter int          NUM_REC = 9
) (
    input  logic [7:0] idx_i,
    input  logic [7:0] timer_i,
    input  logic [7:0] rec_base_i,
    output logic [7:0] byte_o
);
    localparam logic [7:0] NREC_B = 8'(NUM_REC);

    always_comb begin
        case (idx_i)
            8'd0:    byte_o = VERSION[15:8];
            8'd1:    byte_o = VERSION[7:0];
            8'd3:    byte_o = timer_i;
            8'd4:    byte_o = NREC_B;
            8'd6:    byte_o = rec_base_i;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import cseq_pkg::*;
#(
    parameter int          NUM_REC   = 9,
    parameter int          REC_BYTES = 11,
    parameter logic [15:0] VERSION   = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  start_addr_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [7:0]  mem_addr_o,
    output logic        mem_we_o,
    output logic [7:0]  mem_wdata_o,
    input  logic [7:0]  mem_rdata_i,
    output logic        stat_clr_o,
    output logic        stat_run_o,
    output logic        stat_halt_o,
    output logic [15:0] chan_mask_o,
    output logic [7:0]  timer_o,
    output logic [7:0]  rec_idx_o,
    input  logic [7:0]  rec_byte_i
);
    localparam int         DUMP_LEN   = NUM_REC * REC_BYTES;
    localparam logic [7:0] DUMP_LEN_B = 8'(DUMP_LEN);
    localparam logic [7:0] INFO_LEN_B = 8'(INFO_LEN);

    state_e      state;
    logic [7:0]  pc, op_q, dest_q, wcnt, wlen, rec_base;
    logic [2:0]  opnd_left;
    logic [31:0] opbuf;
    logic        is_dump, done_q, err_q;
    logic [15:0] mask_q;
    logic [7:0]  timer_q;

    logic        op_known;
    logic [2:0]  op_nopnd;
    logic [7:0]  info_byte, blk_len;
    logic [8:0]  blk_end;
    logic        opcode_phase;

    cseq_decode u_dec (
        .op_i     (mem_rdata_i),
        .known_o  (op_known),
        .n_opnd_o (op_nopnd)
    );

    cseq_info #(.VERSION(VERSION), .NUM_REC(NUM_REC)) u_info (
        .idx_i      (wcnt),
        .timer_i    (timer_q),
        .rec_base_i (rec_base),
        .byte_o     (info_byte)
    );

    assign opcode_phase = (opnd_left == 3'd0);
    assign blk_len      = (op_q == OP_DUMP) ? DUMP_LEN_B : INFO_LEN_B;
    assign blk_end      = {1'b0, opbuf[7:0]} + {1'b0, blk_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            pc        <= 8'h00;
            op_q      <= 8'h00;
            opnd_left <= 3'd0;
            opbuf     <= 32'h0;
            dest_q    <= 8'h00;
            wcnt      <= 8'h00;
            wlen      <= 8'h00;
            is_dump   <= 1'b0;
            mask_q    <= 16'h0;
            timer_q   <= 8'h00;
            rec_base  <= 8'h80;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_i) begin
                        pc        <= start_addr_i;
                        err_q     <= 1'b0;
                        opnd_left <= 3'd0;
                        state     <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    state <= (pc == LAST_ADDR) ? S_FAULT : S_LATCH;
                end
                S_LATCH: begin
                    pc <= pc + 8'd1;
                    if (opcode_phase) begin
                        op_q <= mem_rdata_i;
                        if (!op_known)                 state <= S_FAULT;
                        else if (mem_rdata_i == OP_END) state <= S_FINISH;
                        else begin
                            opnd_left <= op_nopnd;
                            state     <= S_FETCH;
                        end
                    end else begin
                        opbuf     <= {opbuf[23:0], mem_rdata_i};
                        opnd_left <= opnd_left - 3'd1;
                        state     <= (opnd_left == 3'd1) ? S_EXEC : S_FETCH;
                    end
                end
                S_EXEC: begin
                    case (op_q)
                        OP_MASK: begin
                            mask_q <= opbuf[15:0];
                            state  <= S_FETCH;
                        end
                        OP_TICK: begin
                            if (opbuf[31:24] != 8'h00) state <= S_FAULT;
                            else begin
                                timer_q <= opbuf[23:16];
                                state   <= S_FETCH;
                            end
                        end
                        OP_DUMP, OP_INFO: begin
                            if (blk_end > 9'd255) state <= S_FAULT;
                            else begin
                                dest_q  <= opbuf[7:0];
                                wcnt    <= 8'h00;
                                wlen    <= blk_len;
                                is_dump <= (op_q == OP_DUMP);
                                if (op_q == OP_DUMP) rec_base <= opbuf[7:0];
                                state   <= S_WRITE;
                            end
                        end
                        default: state <= S_FAULT;
                    endcase
                end
                S_WRITE: begin
                    wcnt <= wcnt + 8'd1;
                    if (wcnt == wlen - 8'd1) state <= S_FETCH;
                end
                S_FINISH: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                S_FAULT: begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                    state  <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy_o      = (state != S_IDLE);
        done_o      = done_q;
        err_o       = err_q;
        mem_we_o    = (state == S_WRITE);
        mem_addr_o  = (state == S_WRITE) ? dest_q + wcnt : pc;
        mem_wdata_o = is_dump ? rec_byte_i : info_byte;
        rec_idx_o   = wcnt;
        stat_clr_o  = (state == S_LATCH) && opcode_phase && (mem_rdata_i == OP_CLR);
        stat_run_o  = (state == S_LATCH) && opcode_phase && (mem_rdata_i == OP_RUN);
        stat_halt_o = (state == S_LATCH) && opcode_phase && (mem_rdata_i == OP_HALT);
        chan_mask_o = mask_q;
        timer_o     = timer_q;
    end
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic        mem_we_o,
    input logic        stat_clr_o,
    input logic        stat_run_o,
    input logic        stat_halt_o,
    input logic [15:0] chan_mask_o
);
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_pulse_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_clr_o, stat_run_o, stat_halt_o}));

    assert_pulse_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_o || stat_run_o || stat_halt_o) |-> busy_o);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_we_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(chan_mask_o));
endmodule

bind prog_sequencer prog_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .mem_we_o    (mem_we_o),
    .stat_clr_o  (stat_clr_o),
    .stat_run_o  (stat_run_o),
    .stat_halt_o (stat_halt_o),
    .chan_mask_o (chan_mask_o)
);

// File: tb/prog_sequencer_bench.sv
module prog_sequencer_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          NREC       = 2;
    localparam int          RBYTES     = 11;
    localparam int          DLEN       = NREC * RBYTES;
    localparam logic [15:0] VER        = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  start_addr_i = 8'h00;
    logic        busy_o, done_o, err_o, mem_we_o;
    logic [7:0]  mem_addr_o, mem_wdata_o, mem_rdata_i, timer_o, rec_idx_o, rec_byte_i;
    logic        stat_clr_o, stat_run_o, stat_halt_o;
    logic [15:0] chan_mask_o;

    logic [7:0]  mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_addr = 8'h00, tb_wd = 8'h00;
    int          n_chk = 0, n_fail = 0;
    int          cnt_clr = 0, cnt_run = 0, cnt_halt = 0, cnt_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we_o)   mem[mem_addr_o] <= mem_wdata_o;
        else if (tb_we) mem[tb_addr]    <= tb_wd;
        mem_rdata_i <= mem[mem_addr_o];
        if (stat_clr_o)  cnt_clr  <= cnt_clr + 1;
        if (stat_run_o)  cnt_run  <= cnt_run + 1;
        if (stat_halt_o) cnt_halt <= cnt_halt + 1;
        if (done_o)      cnt_done <= cnt_done + 1;
    end

    assign rec_byte_i = rec_idx_o * 8'd13 + 8'd5;

    prog_sequencer #(.NUM_REC(NREC), .REC_BYTES(RBYTES), .VERSION(VER)) u_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .stat_clr_o(stat_clr_o), .stat_run_o(stat_run_o),
        .stat_halt_o(stat_halt_o), .chan_mask_o(chan_mask_o), .timer_o(timer_o),
        .rec_idx_o(rec_idx_o), .rec_byte_i(rec_byte_i)
    );

    function automatic logic [7:0] rec_val(input int k);
        return 8'(k * 13 + 5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) check(1'b0, "watchdog", t, 0);
    endtask

    task automatic launch(input logic [7:0] a);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
    endtask

    initial begin
        logic [7:0] tmr_exp;
        int c0, r0, h0, d0;
        bit ok;

        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R1 reset status", {busy_o, done_o, err_o}, 0);
        check(chan_mask_o == 16'h0 && timer_o == 8'h0, "R1 reset mask/timer", chan_mask_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: pulse opcodes then END
        poke(8'h10, 8'h10); poke(8'h11, 8'h11); poke(8'h12, 8'h12);
        poke(8'h13, 8'h10); poke(8'h14, 8'h00);
        c0 = cnt_clr; r0 = cnt_run; h0 = cnt_halt;
        launch(8'h10);
        check(!busy_o && !err_o, "R3 clean end", {busy_o, err_o}, 0);
        @(negedge clk);
        check(!done_o, "R3 done single cycle", done_o, 0);
        check(cnt_clr - c0 == 2, "R2 clear pulses", cnt_clr - c0, 2);
        check(cnt_run - r0 == 1 && cnt_halt - h0 == 1, "R2 run/halt pulses",
              (cnt_run - r0) * 16 + (cnt_halt - h0), 17);

        // R4: walking masks
        poke(8'h20, 8'h14); poke(8'h23, 8'h00);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] m;
            m = (16'h1 << i) ^ 16'h5AC3;
            poke(8'h21, m[15:8]); poke(8'h22, m[7:0]);
            launch(8'h20);
            check(chan_mask_o == m && !err_o, "R4 mask load", chan_mask_o, m);
        end

        // R5: prescale x timer cross
        tmr_exp = timer_o;
        poke(8'h30, 8'h15); poke(8'h33, 8'h77); poke(8'h34, 8'h88); poke(8'h35, 8'h00);
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 3; v++) begin
                logic [7:0] tv;
                tv = (v == 0) ? 8'h00 : (v == 1) ? 8'h37 : 8'hFF;
                poke(8'h31, 8'(p)); poke(8'h32, tv);
                launch(8'h30);
                if (p == 0) tmr_exp = tv;
                check(timer_o == tmr_exp && err_o == (p != 0), "R5 timer/prescale",
                      {err_o, timer_o}, {(p != 0), tmr_exp});
            end
        end
        poke(8'h31, 8'h00); poke(8'h32, 8'h4B);
        launch(8'h30);
        tmr_exp = 8'h4B;

        // R6 / R10: dump destination sweep
        poke(8'h00, 8'h13); poke(8'h02, 8'h00);
        for (int d = 8'h20; d < 256; d++) begin
            poke(8'h01, 8'(d));
            poke(8'(d), 8'hEE);
            launch(8'h00);
            if (d + DLEN > 255) begin
                check(err_o && mem[d] == 8'hEE, "R10 dump overrun refused", {err_o, mem[d]}, 9'h1EE);
            end else begin
                ok = !err_o;
                for (int k = 0; k < DLEN; k++) if (mem[d + k] != rec_val(k)) ok = 1'b0;
                check(ok, "R6 dump contents", mem[d], rec_val(0));
            end
        end

        // R7 / R10: info block
        poke(8'h00, 8'h31); poke(8'h01, 8'h40);
        poke(8'h47, 8'hEE); poke(8'h48, 8'hEE); poke(8'h49, 8'hEE);
        launch(8'h00);
        ok = !err_o && mem[8'h40] == VER[15:8] && mem[8'h41] == VER[7:0] && mem[8'h42] == 8'h00
             && mem[8'h43] == tmr_exp && mem[8'h44] == 8'(NREC) && mem[8'h45] == 8'h00
             && mem[8'h46] == 8'hE9 && mem[8'h47] == 8'h00 && mem[8'h48] == 8'h00 && mem[8'h49] == 8'h00;
        check(ok, "R7 info block", mem[8'h46], 8'hE9);
        poke(8'h01, 8'hF5);
        launch(8'h00);
        check(!err_o && mem[8'hFE] == 8'h00 && mem[8'hF5] == VER[15:8], "R7 info at top edge", mem[8'hF5], VER[15:8]);
        poke(8'h01, 8'hF6); poke(8'hF6, 8'hEE);
        launch(8'h00);
        check(err_o && mem[8'hF6] == 8'hEE, "R10 info overrun refused", {err_o, mem[8'hF6]}, 9'h1EE);
        repeat (5) @(negedge clk);
        check(err_o, "R11 err held while idle", err_o, 1);

        // R8: every first opcode
        poke(8'h41, 8'h00); poke(8'h42, 8'h00); poke(8'h43, 8'h00);
        poke(8'h44, 8'h00); poke(8'h45, 8'h00);
        for (int o = 0; o < 256; o++) begin
            bit good;
            good = (o == 8'h00) || (o >= 8'h10 && o <= 8'h15) || (o == 8'h31);
            poke(8'h40, 8'(o));
            launch(8'h40);
            check(err_o == !good, "R8 opcode validity", err_o, !good);
        end

        // R9: running into the top address
        poke(8'hFC, 8'h10); poke(8'hFD, 8'h10); poke(8'hFE, 8'h10); poke(8'hFF, 8'h00);
        c0 = cnt_clr;
        launch(8'hFC);
        check(err_o && cnt_clr - c0 == 3, "R9 overrun at opcode", cnt_clr - c0, 3);
        c0 = cnt_clr;
        poke(8'hFF, 8'h10);
        launch(8'hFF);
        check(err_o && cnt_clr == c0, "R9 0xFF never executed", cnt_clr - c0, 0);
        poke(8'h50, 8'h14); poke(8'h51, 8'h12); poke(8'h52, 8'h34); poke(8'h53, 8'h00);
        launch(8'h50);
        poke(8'hFD, 8'h14); poke(8'hFE, 8'hAA);
        launch(8'hFD);
        check(err_o && chan_mask_o == 16'h1234, "R9 overrun in operand", chan_mask_o, 16'h1234);

        // R1: start while busy ignored
        poke(8'h00, 8'h13); poke(8'h01, 8'h20); poke(8'h02, 8'h00);
        poke(8'h60, 8'h31); poke(8'h61, 8'hA0); poke(8'h62, 8'h00); poke(8'hA0, 8'hEE);
        d0 = cnt_done;
        @(negedge clk); start_i = 1'b1; start_addr_i = 8'h00;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); start_i = 1'b1; start_addr_i = 8'h60;
        @(negedge clk); start_i = 1'b0;
        wait_done();
        repeat (80) @(negedge clk);
        check(cnt_done - d0 == 1 && mem[8'hA0] == 8'hEE && mem[8'h20] == rec_val(0),
              "R1 start while busy ignored", cnt_done - d0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule